// File: doc/BRIEF.md
# Audio Transfer Sample Counter with Interrupt

This block counts audio samples moved between the host and a codec. Playback and capture each have their own counter. The host loads a 16-bit reload value into each counter as two byte writes. Byte strobes from the transfer path advance a per-direction byte position. A sample is complete after one, two or four bytes, depending on sample width and channel count. Each completed sample decrements the counter. When a completed sample finds the counter at zero, the counter reloads from the reload value and raises a sticky interrupt flag for that direction.

For capture, the block also reports which byte the host reads next. Two status bits give the channel (left or right) and the byte half (low or high). The order is fixed: left before right, and the low byte before the high byte.

A reload value of N-1 therefore gives one interrupt every N samples, whatever the format.

Top module: `smp_xfer_counter`

## Requirements
- R1: `reg_sel` picks the target register: bit 1 = 0 for playback, 1 for capture; bit 0 = 0 for the low byte, 1 for the high byte. A write with `reg_wr` high stores `reg_wdata` into that byte. `reg_rdata` always returns the stored byte that `reg_sel` selects.
- R2: A write to either byte of a direction's reload value loads that direction's counter with the new 16-bit value and restarts its byte position at the first byte. The write takes priority over a strobe in the same cycle.
- R3: With reload value B, the direction's interrupt flag rises on the clock edge that completes sample B+1 after the load. After that it rises every B+1 samples, because the counter reloads from B.
- R4: The number of byte strobes per sample is 1 for 8-bit mono, 2 for 8-bit stereo, 2 for 16-bit mono and 4 for 16-bit stereo. `*_fmt_wide`=1 selects 16-bit and `*_fmt_stereo`=1 selects stereo.
- R5: An interrupt flag stays set until a clear pulse for that direction. If the flag is set and cleared in the same cycle, the set wins.
- R6: `play_irq` and `cap_irq` are independent, and `irq` is their OR.
- R7: While a direction's enable is low, its byte strobes have no effect and its request output (`play_req` or `cap_req`) is low. The enable may change at any time without losing the byte position or the count.
- R8: `cap_next_left` is 1 when the next capture byte belongs to the left channel or to a mono sample. It is 0 for right-channel bytes, which are the third and fourth bytes of 16-bit stereo and the second byte of 8-bit stereo.
- R9: `cap_next_upper` is 1 when the next capture byte is a high byte, or whenever the format is 8-bit. It is 0 for the low byte of a 16-bit sample.
- R10: After reset, both reload values and counters are zero, every byte position is at the first byte, and both flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Reload-byte write strobe |
| reg_sel | input | 2 | Register select: direction and byte half |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Readback of the selected reload byte |
| play_en | input | 1 | Playback enable |
| cap_en | input | 1 | Capture enable |
| play_fmt_wide | input | 1 | Playback samples are 16-bit |
| play_fmt_stereo | input | 1 | Playback samples are stereo |
| cap_fmt_wide | input | 1 | Capture samples are 16-bit |
| cap_fmt_stereo | input | 1 | Capture samples are stereo |
| play_byte_stb | input | 1 | One playback byte transferred |
| cap_byte_stb | input | 1 | One capture byte transferred |
| play_irq_clr | input | 1 | Clear pulse for the playback flag |
| cap_irq_clr | input | 1 | Clear pulse for the capture flag |
| play_irq | output | 1 | Playback interrupt flag |
| cap_irq | output | 1 | Capture interrupt flag |
| irq | output | 1 | OR of both flags |
| play_req | output | 1 | Playback request, gated by enable |
| cap_req | output | 1 | Capture request, gated by enable |
| cap_next_left | output | 1 | Next capture byte is left or mono |
| cap_next_upper | output | 1 | Next capture byte is high or 8-bit |

## Verification
The assertions check the following on every cycle:
- a flag, once set, holds until a clear;
- a flag rises only on a counter wrap;
- each completed sample lowers the counter by one, and a wrap reloads the counter from the reload value;
- the byte position returns to the first byte after the last byte of a sample;
- the byte position holds while no strobe and no restart are present.

Some behaviour only the bench scenarios can show. These are the exact number of bytes between interrupts for each of the four formats, the byte order reported by the capture status, and readback of partly written reload values. They also include set-against-clear collisions and the effect of enable toggles in the middle of a sample. A behavioural model predicts all of these and is compared with the outputs on every clock.

// File: rtl/smpcnt_pkg.sv
package smpcnt_pkg;

  // Sample format seen by one transfer direction.
  typedef struct packed {
    logic wide;    // 1: 16-bit samples
    logic stereo;  // 1: two channels per sample
  } smp_fmt_t;

  localparam int POS_W = 2;  // enough for four bytes per sample

  // Bytes that make up one sample (R4).
  function automatic logic [POS_W:0] bytes_per_sample(smp_fmt_t f);
    logic [POS_W:0] n;
    case ({f.wide, f.stereo})
      2'b00:   n = 3'd1;
      2'b01:   n = 3'd2;
      2'b10:   n = 3'd2;
      default: n = 3'd4;
    endcase
    return n;
  endfunction

  // True when the byte at position pos closes the sample.
  // ">=" keeps a format change mid-sample from running past the end.
  function automatic logic pos_is_last(smp_fmt_t f, logic [POS_W-1:0] pos);
    return ({1'b0, pos} >= (bytes_per_sample(f) - 3'd1));
  endfunction

  // Byte order: left before right, low byte before high byte (R8).
  function automatic logic pos_is_right(smp_fmt_t f, logic [POS_W-1:0] pos);
    return f.stereo && (f.wide ? pos[1] : pos[0]);
  endfunction

  // An 8-bit sample always reports as the upper byte (R9).
  function automatic logic pos_is_upper(smp_fmt_t f, logic [POS_W-1:0] pos);
    return !f.wide || pos[0];
  endfunction

endpackage

// File: rtl/smpcnt_base_reg.sv
// Reload value for one direction, written one byte at a time.
module smpcnt_base_reg #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  base_q,   // stored value
  output logic [CNT_W-1:0]  base_d,   // value after this cycle's write
  output logic              load      // a write happens this cycle
);

  always_comb begin
    base_d = base_q;
    if (wr_lo) base_d[BYTE_W-1:0]     = wdata;
    if (wr_hi) base_d[CNT_W-1:BYTE_W] = wdata;
  end

  assign load = wr_lo | wr_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end

  AST_BASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(base_q)) else $error("reload value changed without write"); // R1

endmodule

// File: rtl/smpcnt_byte_track.sv
// Position of the next byte inside the current sample.
module smpcnt_byte_track
  import smpcnt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  smp_fmt_t         fmt,
  input  logic             stb,          // already gated by enable
  input  logic             restart,      // reload-value write
  output logic [POS_W-1:0] pos_q,
  output logic             sample_done,  // event: last byte of a sample
  output logic             next_right,
  output logic             next_upper
);

  assign sample_done = stb && !restart && pos_is_last(fmt, pos_q);
  assign next_right  = pos_is_right(fmt, pos_q);
  assign next_upper  = pos_is_upper(fmt, pos_q);

  always_ff @(posedge clk) begin
    if (!rst_n)           pos_q <= '0;
    else if (restart)     pos_q <= '0;
    else if (sample_done) pos_q <= '0;
    else if (stb)         pos_q <= pos_q + 1'b1;
  end

  AST_POS_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    sample_done |=> pos_q == '0) else $error("position did not return"); // R4

  AST_POS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !stb && !restart |=> $stable(pos_q)) else $error("position moved idle"); // R7

endmodule

// File: rtl/smpcnt_down_ctr.sv
// Sample down-counter with reload on underflow and a sticky flag.
module smpcnt_down_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] base,
  input  logic             tick,      // one completed sample
  input  logic             irq_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap,      // event: underflow this cycle
  output logic             irq_q
);

  assign wrap = tick && !load && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (load)  cnt_q <= load_val;
    else if (wrap)  cnt_q <= base;
    else if (tick)  cnt_q <= cnt_q - 1'b1;
  end

  // Set wins over clear.
  always_ff @(posedge clk) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (wrap)    irq_q <= 1'b1;
    else if (irq_clr) irq_q <= 1'b0;
  end

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !irq_clr |=> irq_q) else $error("flag dropped"); // R5

  AST_IRQ_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(wrap)) else $error("flag rose without wrap"); // R3

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !load && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1)
    else $error("count step wrong"); // R2

  AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt_q == $past(base)) else $error("reload wrong"); // R3

endmodule

// File: rtl/smp_xfer_counter.sv
// Playback and capture sample counters with sticky interrupts.
module smp_xfer_counter
  import smpcnt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              play_en,
  input  logic              cap_en,
  input  logic              play_fmt_wide,
  input  logic              play_fmt_stereo,
  input  logic              cap_fmt_wide,
  input  logic              cap_fmt_stereo,
  input  logic              play_byte_stb,
  input  logic              cap_byte_stb,
  input  logic              play_irq_clr,
  input  logic              cap_irq_clr,
  output logic              play_irq,
  output logic              cap_irq,
  output logic              irq,
  output logic              play_req,
  output logic              cap_req,
  output logic              cap_next_left,
  output logic              cap_next_upper
);

  localparam int CNT_W = 2 * BYTE_W;
  localparam int N_DIR = 2;   // 0: playback, 1: capture

  // Per-direction views of the ports.
  logic     [N_DIR-1:0] en_v, stb_v, clr_v;
  smp_fmt_t [N_DIR-1:0] fmt_v;

  assign en_v  = {cap_en, play_en};
  assign stb_v = {cap_byte_stb, play_byte_stb};
  assign clr_v = {cap_irq_clr, play_irq_clr};
  assign fmt_v[0] = '{wide: play_fmt_wide, stereo: play_fmt_stereo};
  assign fmt_v[1] = '{wide: cap_fmt_wide,  stereo: cap_fmt_stereo};

  // Named internal events, one per direction.
  logic [N_DIR-1:0]            load_v, done_v, wrap_v, irq_v, right_v, upper_v;
  logic [N_DIR-1:0][CNT_W-1:0] base_q_v, base_d_v, cnt_v;
  logic [N_DIR-1:0][POS_W-1:0] pos_v;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    logic sel_here;
    assign sel_here = reg_wr && (reg_sel[1] == d[0]);

    smpcnt_base_reg #(.BYTE_W(BYTE_W)) u_base (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_lo  (sel_here && !reg_sel[0]),
      .wr_hi  (sel_here &&  reg_sel[0]),
      .wdata  (reg_wdata),
      .base_q (base_q_v[d]),
      .base_d (base_d_v[d]),
      .load   (load_v[d])
    );

    smpcnt_byte_track u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .fmt         (fmt_v[d]),
      .stb         (stb_v[d] && en_v[d]),
      .restart     (load_v[d]),
      .pos_q       (pos_v[d]),
      .sample_done (done_v[d]),
      .next_right  (right_v[d]),
      .next_upper  (upper_v[d])
    );

    smpcnt_down_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_v[d]),
      .load_val (base_d_v[d]),
      .base     (base_q_v[d]),
      .tick     (done_v[d]),
      .irq_clr  (clr_v[d]),
      .cnt_q    (cnt_v[d]),
      .wrap     (wrap_v[d]),
      .irq_q    (irq_v[d])
    );

    AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !en_v[d] && !load_v[d] |=> $stable(cnt_v[d]) && $stable(pos_v[d]))
      else $error("disabled direction advanced"); // R7
  end

  // Readback: bit 1 picks direction, bit 0 picks byte half.
  always_comb begin
    logic [CNT_W-1:0] b;
    b = base_q_v[reg_sel[1]];
    reg_rdata = reg_sel[0] ? b[CNT_W-1:BYTE_W] : b[BYTE_W-1:0];
  end

  assign play_irq       = irq_v[0];
  assign cap_irq        = irq_v[1];
  assign irq            = |irq_v;
  assign play_req       = play_en;
  assign cap_req        = cap_en;
  assign cap_next_left  = !right_v[1];
  assign cap_next_upper = upper_v[1];

  AST_FLAGS_SEPARATE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_v[0] && !wrap_v[1] && !cap_irq |=> !cap_irq) else $error("cross-set"); // R6

endmodule

// File: tb/test_smp_xfer_counter.sv
`timescale 1ns/1ps
module test_smp_xfer_counter;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [1:0] reg_sel;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic play_en, cap_en, play_fmt_wide, play_fmt_stereo, cap_fmt_wide, cap_fmt_stereo;
  logic play_byte_stb, cap_byte_stb, play_irq_clr, cap_irq_clr;
  logic play_irq, cap_irq, irq, play_req, cap_req, cap_next_left, cap_next_upper;

  always #2.5 clk = ~clk;   // 200 MHz

  smp_xfer_counter i_smp_xfer_counter (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural reference model.
  int m_base[2], m_cnt[2], m_pos[2];
  bit m_irq[2];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int nbytes(bit w, bit s);
    return (w ? 2 : 1) * (s ? 2 : 1);
  endfunction

  task automatic model_step();
    bit en[2], stb[2], clr[2], w[2], s[2];
    en  = '{play_en, cap_en};   stb = '{play_byte_stb, cap_byte_stb};
    clr = '{play_irq_clr, cap_irq_clr};
    w   = '{play_fmt_wide, cap_fmt_wide}; s = '{play_fmt_stereo, cap_fmt_stereo};
    if (!rst_n) begin
      for (int d = 0; d < 2; d++) begin m_base[d] = 0; m_cnt[d] = 0; m_pos[d] = 0; m_irq[d] = 0; end
      return;
    end
    for (int d = 0; d < 2; d++) begin
      bit fire = 0;
      if (reg_wr && reg_sel[1] == d[0]) begin
        if (reg_sel[0]) m_base[d] = (m_base[d] % 256) + reg_wdata * 256;
        else            m_base[d] = (m_base[d] / 256) * 256 + reg_wdata;
        m_cnt[d] = m_base[d];
        m_pos[d] = 0;
      end else if (stb[d] && en[d]) begin
        if (m_pos[d] + 1 >= nbytes(w[d], s[d])) begin
          m_pos[d] = 0;
          if (m_cnt[d] == 0) begin m_cnt[d] = m_base[d]; fire = 1; end
          else m_cnt[d]--;
        end else m_pos[d]++;
      end
      if (fire) m_irq[d] = 1;
      else if (clr[d]) m_irq[d] = 0;
    end
  endtask

  task automatic compare();
    int half, b;
    bit left, upper;
    b = m_base[reg_sel[1]];
    chk("R1 readback", reg_rdata, reg_sel[0] ? b / 256 : b % 256);
    chk("R3/R5 play_irq", play_irq, m_irq[0]);
    chk("R3/R5 cap_irq", cap_irq, m_irq[1]);
    chk("R6 irq", irq, m_irq[0] | m_irq[1]);
    chk("R7 play_req", play_req, play_en);
    chk("R7 cap_req", cap_req, cap_en);
    half  = nbytes(cap_fmt_wide, cap_fmt_stereo) / 2;
    left  = !cap_fmt_stereo || (m_pos[1] < half);
    upper = !cap_fmt_wide || (m_pos[1] % 2 == 1);
    chk("R8 cap_next_left", cap_next_left, left);
    chk("R9 cap_next_upper", cap_next_upper, upper);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle_inputs();
    reg_wr = 0; play_byte_stb = 0; cap_byte_stb = 0; play_irq_clr = 0; cap_irq_clr = 0;
  endtask

  task automatic wr_base(int dir, int val);
    reg_wr = 1; reg_sel = {dir[0], 1'b0}; reg_wdata = val[7:0]; tick();
    reg_sel = {dir[0], 1'b1}; reg_wdata = val[15:8]; tick();
    reg_wr = 0;
  endtask

  task automatic send(int dir, int n);
    for (int i = 0; i < n; i++) begin
      if (dir == 0) play_byte_stb = 1; else cap_byte_stb = 1;
      tick();
    end
    play_byte_stb = 0; cap_byte_stb = 0;
  endtask

  task automatic clear_both();
    play_irq_clr = 1; cap_irq_clr = 1; tick(); play_irq_clr = 0; cap_irq_clr = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle_inputs(); reg_sel = 0; reg_wdata = 0;
    play_en = 0; cap_en = 0;
    play_fmt_wide = 0; play_fmt_stereo = 0; cap_fmt_wide = 0; cap_fmt_stereo = 0;
    repeat (3) tick();
    rst_n = 1; tick();
    // R10 reset state
    chk("R10 irq after reset", irq, 0);
    chk("R10 next_left after reset", cap_next_left, 1);

    // R1: partial write readback
    reg_wr = 1; reg_sel = 2'b11; reg_wdata = 8'hA5; tick(); reg_wr = 0;
    chk("R1 high byte", reg_rdata, 8'hA5);
    reg_sel = 2'b10; tick();
    chk("R1 low byte untouched", reg_rdata, 0);

    // R3/R4: 16-bit stereo playback, base 2 -> 3 samples = 12 bytes
    play_en = 1; play_fmt_wide = 1; play_fmt_stereo = 1;
    wr_base(0, 2);
    send(0, 11);
    chk("R3 no irq before last byte", play_irq, 0);
    send(0, 1);
    chk("R3 R4 irq after 12 bytes", play_irq, 1);
    chk("R6 capture flag stays clear", cap_irq, 0);
    // R5 sticky, then set-wins collision
    send(0, 5);
    chk("R5 flag held", play_irq, 1);
    clear_both();
    chk("R5 cleared", play_irq, 0);
    send(0, 6);                     // 11 bytes into next period
    play_irq_clr = 1; send(0, 1); play_irq_clr = 0;
    chk("R5 set wins over clear", play_irq, 1);
    clear_both();

    // R7: strobes ignored while disabled
    play_en = 0; send(0, 40);
    chk("R7 disabled no irq", play_irq, 0);
    chk("R7 req low", play_req, 0);
    play_en = 1; send(0, 12);
    chk("R7 count kept over disable", play_irq, 1);
    clear_both();

    // R8/R9: capture byte order in each format
    cap_en = 1; cap_fmt_wide = 1; cap_fmt_stereo = 1; wr_base(1, 0);
    chk("R8 byte0 left", cap_next_left, 1); chk("R9 byte0 low", cap_next_upper, 0);
    send(1, 1); chk("R9 byte1 high", cap_next_upper, 1);
    send(1, 1); chk("R8 byte2 right", cap_next_left, 0);
    send(1, 2); chk("R4 base0 irq per sample", cap_irq, 1);
    clear_both();
    cap_fmt_wide = 0; wr_base(1, 1);
    chk("R9 8-bit reports upper", cap_next_upper, 1);
    send(1, 1); chk("R8 8-bit stereo right", cap_next_left, 0);
    send(1, 3); chk("R4 8-bit stereo 4 bytes", cap_irq, 1);
    clear_both();
    cap_fmt_stereo = 0; wr_base(1, 3);
    send(1, 3); chk("R4 8-bit mono early", cap_irq, 0);
    send(1, 1); chk("R4 8-bit mono 4 bytes", cap_irq, 1);
    clear_both();
    // R2: rewrite restarts count mid-period
    cap_fmt_wide = 1; wr_base(1, 1);
    send(1, 3); wr_base(1, 1); send(1, 3);
    chk("R2 restart on write", cap_irq, 0);
    send(1, 1); chk("R2 irq after reload", cap_irq, 1);
    clear_both();

    // Mixed traffic compared every clock
    wr_base(0, 3); wr_base(1, 2);
    for (int i = 0; i < 4000; i++) begin
      reg_wr = ($urandom % 60 == 0);
      reg_sel = 2'($urandom); reg_wdata = reg_sel[0] ? 8'd0 : 8'($urandom % 6);
      play_byte_stb = $urandom % 2; cap_byte_stb = $urandom % 2;
      play_irq_clr = ($urandom % 9 == 0); cap_irq_clr = ($urandom % 9 == 0);
      if ($urandom % 40 == 0) play_en = ~play_en;
      if ($urandom % 40 == 0) cap_en = ~cap_en;
      if (m_pos[0] == 0 && $urandom % 30 == 0) {play_fmt_wide, play_fmt_stereo} = 2'($urandom);
      if (m_pos[1] == 0 && $urandom % 30 == 0) {cap_fmt_wide, cap_fmt_stereo} = 2'($urandom);
      tick();
    end
    idle_inputs(); tick();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule